// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block encrypts a single 128-bit block under AES-128. It applies one round per clock and takes eleven round-key applications in all. The round keys come from outside the block: the core drives a round index, and an external key source returns the matching 128-bit round key in the same cycle, with no register in between. Key expansion is not part of the block. One start strobe loads the plaintext and applies round key 0. Rounds 1 to 9 then run as full rounds, and round 10 runs without the column mix. The ciphertext sits in the state register when the done pulse appears, and it stays there until the next encryption is accepted.

The substitution step is computed in logic. Each byte passes through a GF(2^8) inverse, built from a fixed chain of squarings and multiplications, followed by an affine map. No table is indexed by data. Every encryption takes the same number of cycles whatever the key and the data.

Control is a three-state machine:
- `S_IDLE` waits for `start`. On `start` it goes to `S_RUN`.
- `S_RUN` applies the full rounds. It stays in `S_RUN` until the round counter reaches 9, then goes to `S_LAST`.
- `S_LAST` applies the final round and returns to `S_IDLE` unconditionally. The done pulse is raised on that return.

Top module: `aes128_iter_enc`

## Requirements
- R1: While reset is asserted, and right after it is released, `busy` and `done` are 0, `rkey_idx` is 0 and `cipher_out` is all zeros.
- R2: Byte k of a block (k = 0..15) occupies bits [127-8k : 120-8k] of `plain_in`, `rkey_in` and `cipher_out`. Byte k is row k mod 4, column k div 4 of the state matrix.
- R3: `rkey_idx` is 0 whenever the block is idle. After an accepted start it reads 1, 2, ..., 10 in consecutive cycles, and then returns to 0.
- R4: `cipher_out` equals the AES-128 encryption of the plaintext. The sequence is key 0 added first, then nine rounds of substitution, row rotation, column mix and key addition, then a tenth round without the column mix. The round key for index i is taken from `rkey_in` while `rkey_idx` equals i.
- R5: `done` is high for exactly one cycle, in the cycle that follows the 10th rising edge after the edge that sampled `start`. That is 11 cycles counting the start cycle. `busy` is high from the edge after the start edge up to that point. The latency is the same for every key and plaintext.
- R6: A `start` that arrives while `busy` is high has no effect. Round progress, the done timing and the result are unchanged.
- R7: After `done`, `cipher_out` holds its value until the next accepted start, whatever `plain_in` does.
- R8: A `start` given in the same cycle that `done` is high is accepted, so encryptions can run back to back.
- R9: The substitution of each byte is its GF(2^8) inverse modulo x^8+x^4+x^3+x+1, with 0 mapped to 0, followed by the affine map b ^ rotl1 ^ rotl2 ^ rotl3 ^ rotl4 ^ 0x63. As a consequence, the all-zero key and the all-zero plaintext give 66E94BD4EF8A2C3B884CFA59CA342B2E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an encryption when the block is idle |
| plain_in | input | 128 | Plaintext block, byte 0 in the top bits |
| rkey_in | input | 128 | Round key selected by `rkey_idx` |
| rkey_idx | output | 4 | Index of the round key needed this cycle |
| busy | output | 1 | High while rounds are in progress |
| done | output | 1 | One-cycle pulse when `cipher_out` is valid |
| cipher_out | output | 128 | Ciphertext block, byte 0 in the top bits |

## Verification
A wrong state-machine state or round count shows at the ports within a cycle. It appears as a `rkey_idx` step out of sequence or as `done` arriving early or late, so the bench compares the index and `busy` against the expected value in every cycle of every run. A single corrupted byte in the state register, or a wrong S-box or column-mix term, spreads to the whole block within two rounds. It therefore always shows as a ciphertext mismatch at `done`, ten cycles after start, which is checked against published vectors. A start that leaks through while the block is busy shows as a broken index sequence on the very next cycle and as a wrong result.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

    localparam int BLK_W  = 128;
    localparam int BYTE_W = 8;
    localparam int N_ROWS = 4;
    localparam int N_COLS = 4;
    localparam int N_BYTES = N_ROWS * N_COLS;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_LAST = 2'd2
    } enc_state_e;

    // doubling in the field, reduced by the low byte of the polynomial
    function automatic byte_t gf_x2(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_x3(input byte_t a);
        return gf_x2(a) ^ a;
    endfunction

    // shift-and-add product, fixed eight iterations
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // inverse as a^254 through a fixed square/multiply chain; 0 yields 0
    function automatic byte_t gf_inv(input byte_t a);
        byte_t p2, p3, p6, p7, p12, p15, p30, p60, p120, p127;
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p6   = gf_mul(p3, p3);
        p7   = gf_mul(p6, a);
        p12  = gf_mul(p6, p6);
        p15  = gf_mul(p12, p3);
        p30  = gf_mul(p15, p15);
        p60  = gf_mul(p30, p30);
        p120 = gf_mul(p60, p60);
        p127 = gf_mul(p120, p7);
        return gf_mul(p127, p127);
    endfunction

    function automatic byte_t gf_affine(input byte_t b);
        byte_t r1, r2, r3, r4;
        r1 = {b[6:0], b[7]};
        r2 = {b[5:0], b[7:6]};
        r3 = {b[4:0], b[7:5]};
        r4 = {b[3:0], b[7:4]};
        return b ^ r1 ^ r2 ^ r3 ^ r4 ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_sbox_logic.sv
module aes_sbox_logic
    import aes_enc_pkg::*;
(
    input  byte_t din,
    output byte_t dout
);

    byte_t inv_b;

    always_comb begin
        inv_b = gf_inv(din);
        dout  = gf_affine(inv_b);
    end

endmodule

// File: rtl/aes_round_fn.sv
module aes_round_fn
    import aes_enc_pkg::*;
(
    input  logic [BLK_W-1:0] st_in,
    input  logic [BLK_W-1:0] rkey,
    input  logic             final_rnd,
    output logic [BLK_W-1:0] st_out
);

    byte_t sub_b [N_BYTES];
    byte_t sh_b  [N_BYTES];
    byte_t mx_b  [N_BYTES];

    // substitution: one logic S-box per byte
    for (genvar k = 0; k < N_BYTES; k++) begin : g_sub
        aes_sbox_logic u_sb (
            .din  (st_in[BLK_W-1-BYTE_W*k -: BYTE_W]),
            .dout (sub_b[k])
        );
    end

    // row r rotates left by r positions: out(r,c) = in(r,(c+r) mod 4)
    for (genvar c = 0; c < N_COLS; c++) begin : g_shc
        for (genvar r = 0; r < N_ROWS; r++) begin : g_shr
            localparam int SRC = N_ROWS * ((c + r) % N_COLS) + r;
            assign sh_b[N_ROWS*c + r] = sub_b[SRC];
        end
    end

    // column mix, coefficients 2 3 1 1 rotated per row
    for (genvar c = 0; c < N_COLS; c++) begin : g_mix
        localparam int B = N_ROWS * c;
        assign mx_b[B+0] = gf_x2(sh_b[B+0]) ^ gf_x3(sh_b[B+1]) ^ sh_b[B+2] ^ sh_b[B+3];
        assign mx_b[B+1] = sh_b[B+0] ^ gf_x2(sh_b[B+1]) ^ gf_x3(sh_b[B+2]) ^ sh_b[B+3];
        assign mx_b[B+2] = sh_b[B+0] ^ sh_b[B+1] ^ gf_x2(sh_b[B+2]) ^ gf_x3(sh_b[B+3]);
        assign mx_b[B+3] = gf_x3(sh_b[B+0]) ^ sh_b[B+1] ^ sh_b[B+2] ^ gf_x2(sh_b[B+3]);
    end

    // key addition; the final round bypasses the mix
    for (genvar k = 0; k < N_BYTES; k++) begin : g_ark
        assign st_out[BLK_W-1-BYTE_W*k -: BYTE_W] =
            (final_rnd ? sh_b[k] : mx_b[k]) ^ rkey[BLK_W-1-BYTE_W*k -: BYTE_W];
    end

endmodule

// File: rtl/aes_state_reg.sv
module aes_state_reg
    import aes_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             last_rnd,
    input  logic [BLK_W-1:0] plain,
    input  logic [BLK_W-1:0] rkey,
    output logic [BLK_W-1:0] state_q
);

    logic [BLK_W-1:0] nxt;

    aes_round_fn u_rnd (
        .st_in     (state_q),
        .rkey      (rkey),
        .final_rnd (last_rnd),
        .st_out    (nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (load) begin
            state_q <= plain ^ rkey;
        end else if (step) begin
            state_q <= nxt;
        end
    end

    // a load and a round step never coincide (R6)
    p_load_step_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));

endmodule

// File: rtl/aes_enc_ctrl.sv
module aes_enc_ctrl
    import aes_enc_pkg::*;
#(
    parameter int NR = 10,
    parameter int RW = 4
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          load,
    output logic          step,
    output logic          last_rnd,
    output logic          done,
    output logic [RW-1:0] rnd_idx
);

    enc_state_e    st_q, st_d;
    logic [RW-1:0] rnd_q;
    logic          done_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (start) st_d = S_RUN;
            S_RUN:   if (rnd_q == RW'(NR - 1)) st_d = S_LAST;
            S_LAST:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // round counter and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (st_q == S_LAST);
            unique case (st_q)
                S_IDLE:  rnd_q <= start ? RW'(1) : '0;
                S_RUN:   rnd_q <= rnd_q + RW'(1);
                S_LAST:  rnd_q <= '0;
                default: rnd_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        last_rnd = 1'b0;
        unique case (st_q)
            S_IDLE: load = start;
            S_RUN: begin
                busy = 1'b1;
                step = 1'b1;
            end
            S_LAST: begin
                busy     = 1'b1;
                step     = 1'b1;
                last_rnd = 1'b1;
            end
            default: ;
        endcase
    end

    assign done    = done_q;
    assign rnd_idx = rnd_q;

    p_idx_zero_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE) |-> (rnd_q == '0));

    p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RUN) |=> (rnd_q == $past(rnd_q) + RW'(1)));

    p_last_at_nr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_LAST) |-> (rnd_q == RW'(NR)));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
    import aes_enc_pkg::*;
#(
    parameter int NR = 10,
    localparam int RW = $clog2(NR + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [127:0]     plain_in,
    input  logic [127:0]     rkey_in,
    output logic [RW-1:0]    rkey_idx,
    output logic             busy,
    output logic             done,
    output logic [127:0]     cipher_out
);

    logic load, step, last_rnd;

    aes_enc_ctrl #(
        .NR (NR),
        .RW (RW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .load     (load),
        .step     (step),
        .last_rnd (last_rnd),
        .done     (done),
        .rnd_idx  (rkey_idx)
    );

    aes_state_reg u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .last_rnd (last_rnd),
        .plain    (plain_in),
        .rkey     (rkey_in),
        .state_q  (cipher_out)
    );

    p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && rkey_idx != RW'(NR)) |=> (busy && rkey_idx == $past(rkey_idx) + RW'(1)));

    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(cipher_out));

    p_fell_busy_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_idle_start_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && rkey_idx == RW'(1)));

endmodule

// File: tb/aes128_iter_enc_test.sv
module aes128_iter_enc_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] plain_in = '0;
    logic [127:0] rkey_in;
    logic [3:0]   rkey_idx;
    logic         busy, done;
    logic [127:0] cipher_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    logic [127:0] rk_tab [0:10];
    logic [7:0]   sb_tab [0:255];

    // key, plaintext, ciphertext
    localparam int NV = 3;
    localparam logic [383:0] VECS [NV] = '{
        {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
         128'h69c4e0d86a7b0430d8cdb78070b4c55a},
        {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
         128'h3925841d02dc09fbdc118597196a0b32},
        {128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
    };

    aes128_iter_enc uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .plain_in   (plain_in),
        .rkey_in    (rkey_in),
        .rkey_idx   (rkey_idx),
        .busy       (busy),
        .done       (done),
        .cipher_out (cipher_out)
    );

    always #4 clk = ~clk;

    // external key source, combinational on the index
    always_comb rkey_in = (rkey_idx <= 4'd10) ? rk_tab[rkey_idx] : '0;

    function automatic logic [7:0] tb_dbl(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    endfunction

    function automatic logic [7:0] tb_prod(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = '0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = tb_dbl(x);
        end
        return r;
    endfunction

    // exhaustive inverse search, then bitwise affine form (R9)
    task automatic build_sbox();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] inv = '0;
            logic [7:0] s;
            for (int y = 1; y < 256; y++)
                if (tb_prod(8'(v), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
            sb_tab[v] = s;
        end
    endtask

    task automatic expand(input logic [127:0] key);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb_tab[t[31:24]], sb_tab[t[23:16]], sb_tab[t[15:8]], sb_tab[t[7:0]]} ^ {rc, 24'h0};
                rc = tb_dbl(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rk_tab[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    task automatic check(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Starts at a negedge with the block idle (or done high); ends at the negedge where done should be high.
    // inj > 0 holds start high with other data for 3 cycles from round inj.
    task automatic run_enc(input logic [127:0] key, input logic [127:0] pt, input logic [127:0] ct,
                           input int inj, input string tag);
        int seq_err = 0;
        logic [3:0] bad_idx = '0;
        expand(key);
        plain_in = pt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            if (rkey_idx != 4'(k) || !busy || done) begin
                if (seq_err == 0) bad_idx = rkey_idx;
                seq_err++;
            end
            if (inj > 0 && k >= inj && k < inj + 3) begin
                start = 1'b1;
                plain_in = ~pt;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(seq_err == 0, {tag, " R3/R5 index sequence and busy during rounds"}, 128'(bad_idx), 128'(seq_err == 0));
        check(done && !busy && rkey_idx == 4'd0, {tag, " R5 done after 10 edges, busy low, index 0"},
              {125'h0, done, busy, |rkey_idx}, 128'h4);
        check(cipher_out == ct, {tag, " R2/R4 ciphertext"}, cipher_out, ct);
    endtask

    initial begin
        for (int r = 0; r < 11; r++) rk_tab[r] = '0;
        build_sbox();

        // R1 reset state
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1 busy/done in reset", {126'h0, busy, done}, 128'h0);
        check(rkey_idx == 4'd0, "R1 index in reset", 128'(rkey_idx), 128'h0);
        check(cipher_out == '0, "R1 cipher in reset", cipher_out, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && rkey_idx == 4'd0 && cipher_out == '0, "R1 state after release",
              cipher_out, 128'h0);

        // table of vectors, one loop (R4, R9: third entry is all-zero)
        for (int v = 0; v < NV; v++) begin
            run_enc(VECS[v][383:256], VECS[v][255:128], VECS[v][127:0], 0, $sformatf("vec%0d", v));
            plain_in = ~plain_in;
            @(negedge clk);
            check(!done, "R5 done lasts one cycle", 128'(done), 128'h0);
            check(cipher_out == VECS[v][127:0], "R7 cipher holds after done", cipher_out, VECS[v][127:0]);
            repeat (3) @(negedge clk);
        end

        // R7 longer hold with changing input and key table
        plain_in = 128'hdeadbeef;
        expand(128'h55);
        repeat (6) @(negedge clk);
        check(cipher_out == VECS[NV-1][127:0] && !busy, "R7 cipher held while idle", cipher_out, VECS[NV-1][127:0]);

        // R6 start held mid-run with other data
        run_enc(VECS[1][383:256], VECS[1][255:128], VECS[1][127:0], 4, "R6 inject@4");
        @(negedge clk);
        run_enc(VECS[0][383:256], VECS[0][255:128], VECS[0][127:0], 8, "R6 inject@8");

        // R8 back to back: start given in the done cycle
        run_enc(VECS[2][383:256], VECS[2][255:128], VECS[2][127:0], 0, "R8 first");
        run_enc(VECS[1][383:256], VECS[1][255:128], VECS[1][127:0], 0, "R8 back-to-back");
        @(negedge clk);
        check(!done && !busy, "R8 idle after second", {126'h0, done, busy}, 128'h0);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule